// File: doc/BRIEF.md
# Locality Ownership Arbiter

A shared security-device register file is reached through five address windows, one per locality. Only one locality may own the interface at a time. This block holds the current owner and a per-locality access register. Each locality writes its access register to ask for ownership, give it up, take it by force, or acknowledge that it was forced out. Reads return a live view of that register, including whether some other locality is waiting.

Giving up ownership hands it at once to the highest-numbered waiting locality. Taking ownership by force is allowed only for a locality numbered above the current owner. It does not change ownership on the spot. Instead it asks the command engine to abort whatever is in flight. The transfer happens on the cycle the engine answers with its abort-done strobe. At that point the forced-out owner gets a sticky flag that tells it what happened. Every change of owner is signalled by a one-cycle pulse on the new owner's line.

Top module: `locality_arbiter`

## Requirements
- R1: After reset no locality owns the interface: `active_loc` reads 0xFF, all per-locality vectors are 0 and `abort_req` is low. The access register of every locality reads 0x80. Its layout is: bit 7 register-valid (always 1), bit 5 owner, bit 4 forced-out, bit 3 take-over (write only, always reads 0), bit 2 other-waiting, bit 1 wants-ownership. All other bits read 0.
- R2: The locality is `addr[14:12]`, and the access register sits at offset 0 of each 4 KiB window. Three kinds of write are ignored: writes to locality 4, writes to a locality index of 5 or more, and writes to a nonzero offset. Reads of a locality of 5 or more, or of a nonzero offset, return 0xFF.
- R3: A locality that writes bit 1 while there is no owner becomes the owner in the same write, with its wants and take-over flags cleared.
- R4: A locality that writes bit 1 while a different locality owns the interface gets its wants flag set. The owner writing bit 1 has no effect.
- R5: The owner writing bit 5 releases ownership to the highest-numbered locality whose wants flag is set, and that flag is cleared. If none is waiting, the result is no owner (0xFF) and there is no change pulse.
- R6: A non-owner writing bit 5 only clears its own wants flag.
- R7: Bit 2 of a locality's access register reads 1 exactly when some other locality has its wants flag set.
- R8: A take-over write (bit 3) is accepted only when both of these hold: there is no owner or the writer is numbered above the owner; and neither the writer nor any higher locality has a take-over pending. When accepted, `abort_req` rises and stays high until `abort_done`.
- R9: On `abort_done` while `abort_req` is high, the take-over locality becomes owner with its wants and take-over flags cleared. The previous owner, if any, loses ownership and gets its forced-out flag set. Its wants flag is unchanged.
- R10: Writing 1 to bit 4 clears that locality's forced-out flag. Writing 0 there leaves it unchanged.
- R11: `loc_changed` pulses for one cycle, one-hot on the new owner, in the cycle after the clock edge that changed the owner. It pulses only when the owner really changed.
- R12: An accepted take-over cancels the take-over flags of all lower localities, so a later `abort_done` hands ownership to the highest accepted taker. A rejected take-over leaves the pending target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the access register |
| addr | input | 15 | Address; bits [14:12] select the locality |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Access register image of the addressed locality (combinational) |
| abort_done | input | 1 | Command engine has finished the abort |
| abort_req | output | 1 | Abort request towards the command engine |
| active_loc | output | 8 | Current owner index, 0xFF when none |
| loc_active | output | 5 | One-hot owner flag per locality |
| loc_req | output | 5 | Wants-ownership flag per locality |
| loc_seized | output | 5 | Forced-out flag per locality |
| loc_changed | output | 5 | One-cycle pulse on the new owner |

## Verification
A wrong owner register shows up in the cycle after the faulty edge, in three places: `active_loc`, the one-hot `loc_active`, and bit 5 of every locality's read image. A lost or stray wants flag shows up at once in `loc_req` and in the other-waiting bit of every other locality. It then steers the next release to the wrong successor, one write later. A take-over flag cannot be read, so a wrong one stays hidden until the next `abort_done` hands ownership to the wrong locality. The checks therefore compare every output port and all eight read windows after every single write or abort strobe.

// File: rtl/lar_pkg.sv
`timescale 1ns / 1ps
// Package: shared constants for the locality ownership arbiter.
// Holds the access-register bit positions that software decodes and the
// encoding that means "no owner".
package lar_pkg;
    localparam int REG_W    = 8;
    localparam int BIT_WANT = 1;
    localparam int BIT_PEND = 2;
    localparam int BIT_TAKE = 3;
    localparam int BIT_GONE = 4;
    localparam int BIT_OWN  = 5;
    localparam int BIT_VLD  = 7;
    localparam logic [REG_W-1:0] NO_OWNER = 8'hFF;
    localparam logic [REG_W-1:0] BAD_READ = 8'hFF;
endpackage

// File: rtl/lar_addr_dec.sv
`timescale 1ns / 1ps
// Module: lar_addr_dec
// Splits a window address into a locality index and decides whether the
// access reaches a real access register. Assumes one register per window,
// at offset 0, and a locality that software may never write (HW_LOC).
module lar_addr_dec #(
    parameter int NUM_LOC  = 5,
    parameter int LOC_W    = 3,
    parameter int WIN_BITS = 12,
    parameter int HW_LOC   = 4,
    localparam int ADDR_W  = WIN_BITS + LOC_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output logic [LOC_W-1:0]  loc_idx,
    output logic              rd_hit,
    output logic              wr_hit
);
    logic [WIN_BITS-1:0] offset;
    logic                loc_ok;

    // Field extraction: locality from the high bits, offset from the low bits.
    assign loc_idx = addr[WIN_BITS +: LOC_W];
    assign offset  = addr[WIN_BITS-1:0];
    assign loc_ok  = int'(loc_idx) < NUM_LOC;

    // Read and write qualification.
    assign rd_hit = loc_ok && (offset == '0);
    assign wr_hit = wr_en && rd_hit && (int'(loc_idx) != HW_LOC);
endmodule

// File: rtl/lar_own_core.sv
`timescale 1ns / 1ps
// Module: lar_own_core
// Ownership state machine. Holds the owner, wants/take-over/forced-out
// flags per locality and the pending take-over target. Within a cycle the
// abort-done transfer is applied first, then the write bits in the order
// release, forced-out clear, take-over, wants. Assumes wr_loc < NUM_LOC
// whenever wr_hit is high.
module lar_own_core
    import lar_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [LOC_W-1:0]   wr_loc,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               abort_done,
    output logic               own_vld,
    output logic [LOC_W-1:0]   own_idx,
    output logic [NUM_LOC-1:0] req_vec,
    output logic [NUM_LOC-1:0] gone_vec,
    output logic               abort_req,
    output logic [NUM_LOC-1:0] chg_vec
);
    logic               vld_q, n_vld;
    logic [LOC_W-1:0]   idx_q, n_idx;
    logic [NUM_LOC-1:0] req_q, n_req;
    logic [NUM_LOC-1:0] take_q, n_take;
    logic [NUM_LOC-1:0] gone_q, n_gone;
    logic               ab_q, n_ab;
    logic [LOC_W-1:0]   nxt_q, n_nxt;
    logic [NUM_LOC-1:0] chg_q, n_chg;
    logic               top_vld, hi_take, take_ok, is_owner;
    logic [LOC_W-1:0]   top_idx;
    logic               unused_bits;

    assign unused_bits = ^{wr_data[7:6], wr_data[BIT_PEND], wr_data[0]};

    // Next-state computation for ownership and all per-locality flags.
    always_comb begin
        n_vld   = vld_q;
        n_idx   = idx_q;
        n_req   = req_q;
        n_take  = take_q;
        n_gone  = gone_q;
        n_ab    = ab_q;
        n_nxt   = nxt_q;
        n_chg   = '0;
        top_vld = 1'b0;
        top_idx = '0;
        hi_take = 1'b0;
        take_ok = 1'b0;
        is_owner = 1'b0;

        if (ab_q && abort_done) begin
            if (n_vld && (n_idx != nxt_q)) begin
                n_gone[n_idx] = 1'b1;
            end
            if (!n_vld || (n_idx != nxt_q)) begin
                n_chg[nxt_q] = 1'b1;
            end
            n_req[nxt_q]  = 1'b0;
            n_take[nxt_q] = 1'b0;
            n_vld = 1'b1;
            n_idx = nxt_q;
            n_ab  = 1'b0;
        end

        if (wr_hit) begin
            is_owner = n_vld && (n_idx == wr_loc);
            if (wr_data[BIT_OWN]) begin
                if (is_owner) begin
                    n_req[wr_loc] = 1'b0;
                    for (int i = 0; i < NUM_LOC; i++) begin
                        if (n_req[i]) begin
                            top_vld = 1'b1;
                            top_idx = LOC_W'(i);
                        end
                    end
                    n_chg = '0;
                    n_vld = top_vld;
                    n_idx = top_idx;
                    if (top_vld) begin
                        n_req[top_idx]  = 1'b0;
                        n_take[top_idx] = 1'b0;
                        n_chg[top_idx]  = 1'b1;
                    end
                end else begin
                    n_req[wr_loc] = 1'b0;
                end
            end
            if (wr_data[BIT_GONE]) begin
                n_gone[wr_loc] = 1'b0;
            end
            if (wr_data[BIT_TAKE]) begin
                for (int i = 0; i < NUM_LOC; i++) begin
                    if (i > int'(wr_loc) && n_take[i]) begin
                        hi_take = 1'b1;
                    end
                end
                take_ok = (!n_vld || (wr_loc > n_idx)) && !n_take[wr_loc] && !hi_take;
                if (take_ok) begin
                    for (int i = 0; i < NUM_LOC; i++) begin
                        if (i < int'(wr_loc)) begin
                            n_take[i] = 1'b0;
                        end
                    end
                    n_take[wr_loc] = 1'b1;
                    n_ab  = 1'b1;
                    n_nxt = wr_loc;
                end
            end
            if (wr_data[BIT_WANT] && !(n_vld && (n_idx == wr_loc))) begin
                if (n_vld) begin
                    n_req[wr_loc] = 1'b1;
                end else begin
                    n_vld = 1'b1;
                    n_idx = wr_loc;
                    n_req[wr_loc]  = 1'b0;
                    n_take[wr_loc] = 1'b0;
                    n_chg = '0;
                    n_chg[wr_loc]  = 1'b1;
                end
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            idx_q  <= '0;
            req_q  <= '0;
            take_q <= '0;
            gone_q <= '0;
            ab_q   <= 1'b0;
            nxt_q  <= '0;
            chg_q  <= '0;
        end else begin
            vld_q  <= n_vld;
            idx_q  <= n_idx;
            req_q  <= n_req;
            take_q <= n_take;
            gone_q <= n_gone;
            ab_q   <= n_ab;
            nxt_q  <= n_nxt;
            chg_q  <= n_chg;
        end
    end

    // Output mapping.
    assign own_vld   = vld_q;
    assign own_idx   = idx_q;
    assign req_vec   = req_q;
    assign gone_vec  = gone_q;
    assign abort_req = ab_q;
    assign chg_vec   = chg_q;
endmodule

// File: rtl/lar_view.sv
`timescale 1ns / 1ps
// Module: lar_view
// Builds the per-locality register images, the live other-waiting bit and
// the owner outputs. Purely combinational; assumes own_idx < NUM_LOC
// whenever own_vld is high.
module lar_view
    import lar_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic               own_vld,
    input  logic [LOC_W-1:0]   own_idx,
    input  logic [NUM_LOC-1:0] req_vec,
    input  logic [NUM_LOC-1:0] gone_vec,
    input  logic [LOC_W-1:0]   rd_loc,
    input  logic               rd_hit,
    output logic [REG_W-1:0]   rd_data,
    output logic [REG_W-1:0]   active_loc,
    output logic [NUM_LOC-1:0] loc_active
);
    logic [REG_W-1:0] img [NUM_LOC];

    // Owner index on the wide status port.
    assign active_loc = own_vld ? {{(REG_W-LOC_W){1'b0}}, own_idx} : NO_OWNER;

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
        logic others;
        // Ownership flag and other-waiting flag for this locality.
        assign loc_active[g] = own_vld && (int'(own_idx) == g);
        assign others        = |(req_vec & ~(NUM_LOC'(1) << g));
        // Register image of this locality.
        always_comb begin
            img[g]           = '0;
            img[g][BIT_VLD]  = 1'b1;
            img[g][BIT_OWN]  = loc_active[g];
            img[g][BIT_GONE] = gone_vec[g];
            img[g][BIT_PEND] = others;
            img[g][BIT_WANT] = req_vec[g];
        end
    end

    // Read mux over the valid windows.
    always_comb begin
        rd_data = BAD_READ;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (rd_hit && (int'(rd_loc) == i)) begin
                rd_data = img[i];
            end
        end
    end
endmodule

// File: rtl/locality_arbiter.sv
`timescale 1ns / 1ps
// Module: locality_arbiter (top)
// Arbitrates ownership of a shared register interface among NUM_LOC
// localities addressed through per-locality windows. Take-over requests
// go through an abort handshake with the command engine; ownership moves
// on the abort-done strobe.
module locality_arbiter
    import lar_pkg::*;
#(
    parameter int NUM_LOC  = 5,
    parameter int WIN_BITS = 12,
    parameter int HW_LOC   = 4,
    localparam int LOC_W   = $clog2(NUM_LOC),
    localparam int ADDR_W  = WIN_BITS + LOC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    input  logic               abort_done,
    output logic               abort_req,
    output logic [REG_W-1:0]   active_loc,
    output logic [NUM_LOC-1:0] loc_active,
    output logic [NUM_LOC-1:0] loc_req,
    output logic [NUM_LOC-1:0] loc_seized,
    output logic [NUM_LOC-1:0] loc_changed
);
    logic [LOC_W-1:0] loc_idx;
    logic             rd_hit, wr_hit;
    logic             own_vld;
    logic [LOC_W-1:0] own_idx;

    lar_addr_dec #(
        .NUM_LOC (NUM_LOC),
        .LOC_W   (LOC_W),
        .WIN_BITS(WIN_BITS),
        .HW_LOC  (HW_LOC)
    ) u_dec (
        .addr   (addr),
        .wr_en  (wr_en),
        .loc_idx(loc_idx),
        .rd_hit (rd_hit),
        .wr_hit (wr_hit)
    );

    lar_own_core #(
        .NUM_LOC(NUM_LOC),
        .LOC_W  (LOC_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .wr_loc    (loc_idx),
        .wr_data   (wr_data),
        .abort_done(abort_done),
        .own_vld   (own_vld),
        .own_idx   (own_idx),
        .req_vec   (loc_req),
        .gone_vec  (loc_seized),
        .abort_req (abort_req),
        .chg_vec   (loc_changed)
    );

    lar_view #(
        .NUM_LOC(NUM_LOC),
        .LOC_W  (LOC_W)
    ) u_view (
        .own_vld   (own_vld),
        .own_idx   (own_idx),
        .req_vec   (loc_req),
        .gone_vec  (loc_seized),
        .rd_loc    (loc_idx),
        .rd_hit    (rd_hit),
        .rd_data   (rd_data),
        .active_loc(active_loc),
        .loc_active(loc_active)
    );
endmodule

// File: rtl/locality_arbiter_sva.sv
`timescale 1ns / 1ps
// Module: locality_arbiter_sva
// Checker bound to locality_arbiter; observes ports only.
module locality_arbiter_sva #(
    parameter int NUM_LOC  = 5,
    parameter int WIN_BITS = 12,
    parameter int HW_LOC   = 4,
    localparam int LOC_W   = $clog2(NUM_LOC),
    localparam int ADDR_W  = WIN_BITS + LOC_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic               abort_done,
    input logic               abort_req,
    input logic [7:0]         active_loc,
    input logic [NUM_LOC-1:0] loc_active,
    input logic [NUM_LOC-1:0] loc_req,
    input logic [NUM_LOC-1:0] loc_seized,
    input logic [NUM_LOC-1:0] loc_changed
);
    AST_OWNER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (active_loc < 8'(NUM_LOC)) || (active_loc == 8'hFF)); // R1

    AST_HW_LOC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(addr[WIN_BITS +: LOC_W]) == HW_LOC) && !abort_done)
        |=> ($stable(active_loc) && $stable(loc_req) && $stable(loc_seized))); // R2

    AST_OWNER_NOT_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_active & loc_req) == '0); // R3

    AST_ABORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && !abort_done) |=> abort_req); // R8

    AST_CHG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(loc_changed)); // R11

    AST_CHG_IS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_changed != '0) |-> ((active_loc < 8'(NUM_LOC)) && loc_changed[active_loc[LOC_W-1:0]])); // R11

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_gone
        AST_GONE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(loc_seized[g]) |-> $past(abort_done)); // R9
    end
endmodule

bind locality_arbiter locality_arbiter_sva #(
    .NUM_LOC (NUM_LOC),
    .WIN_BITS(WIN_BITS),
    .HW_LOC  (HW_LOC)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .abort_done (abort_done),
    .abort_req  (abort_req),
    .active_loc (active_loc),
    .loc_active (loc_active),
    .loc_req    (loc_req),
    .loc_seized (loc_seized),
    .loc_changed(loc_changed)
);

// File: tb/locality_arbiter_tb.sv
`timescale 1ns / 1ps
module locality_arbiter_tb;
    localparam int NL = 5;
    localparam int WB = 12;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          abort_done = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data, active_loc;
    logic          abort_req;
    logic [NL-1:0] loc_active, loc_req, loc_seized, loc_changed;

    int checks = 0;
    int errors = 0;

    // reference state
    bit          m_vld;
    int          m_idx;
    bit [NL-1:0] m_req, m_take, m_gone, m_chg;
    bit          m_ab;
    int          m_nxt;

    always #10 clk = ~clk;

    locality_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .abort_done(abort_done), .abort_req(abort_req),
        .active_loc(active_loc), .loc_active(loc_active), .loc_req(loc_req),
        .loc_seized(loc_seized), .loc_changed(loc_changed)
    );

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [7:0] img(int l);
        int others = 0;
        for (int j = 0; j < NL; j++) if (j != l && m_req[j]) others = 1;
        return 8'h80 | ((m_vld && m_idx == l) ? 8'h20 : 8'h00) | (m_gone[l] ? 8'h10 : 8'h00)
                     | (others != 0 ? 8'h04 : 8'h00) | (m_req[l] ? 8'h02 : 8'h00);
    endfunction

    task automatic make_owner(int l);
        m_vld = 1; m_idx = l; m_req[l] = 0; m_take[l] = 0;
        m_chg = '0; m_chg[l] = 1;
    endtask

    task automatic model(bit done, bit we, int loc, int off, logic [7:0] d);
        bit hit;
        m_chg = '0;
        if (done && m_ab) begin
            if (m_vld && m_idx != m_nxt) m_gone[m_idx] = 1;
            if (!(m_vld && m_idx == m_nxt)) begin
                make_owner(m_nxt);
            end else begin
                m_req[m_nxt] = 0; m_take[m_nxt] = 0;
            end
            m_ab = 0;
        end
        hit = we && loc < NL && off == 0 && loc != 4;
        if (!hit) return;
        if (d[5]) begin
            if (m_vld && m_idx == loc) begin
                int top = -1;
                m_req[loc] = 0;
                for (int i = NL - 1; i >= 0; i--) if (m_req[i]) begin top = i; break; end
                m_chg = '0;
                if (top < 0) m_vld = 0;
                else make_owner(top);
            end else m_req[loc] = 0;
        end
        if (d[4]) m_gone[loc] = 0;
        if (d[3]) begin
            bit ok = (!m_vld || loc > m_idx) && !m_take[loc];
            for (int i = loc + 1; i < NL; i++) if (m_take[i]) ok = 0;
            if (ok) begin
                for (int i = 0; i < loc; i++) m_take[i] = 0;
                m_take[loc] = 1; m_ab = 1; m_nxt = loc;
            end
        end
        if (d[1] && !(m_vld && m_idx == loc)) begin
            if (m_vld) m_req[loc] = 1;
            else make_owner(loc);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "active_loc", active_loc, m_vld ? m_idx : 32'hFF);
        chk(tag, "loc_active", loc_active, m_vld ? (32'd1 << m_idx) : 0);
        chk(tag, "loc_req", loc_req, m_req);
        chk(tag, "loc_seized", loc_seized, m_gone);
        chk(tag, "loc_changed", loc_changed, m_chg);
        chk(tag, "abort_req", abort_req, m_ab);
        for (int l = 0; l < 8; l++) begin
            addr = AW'(l << WB);
            #1;
            chk(tag, $sformatf("rd_data loc%0d", l), rd_data, (l < NL) ? img(l) : 32'hFF);
        end
        addr = AW'(4);
        #1;
        chk(tag, "rd_data offset", rd_data, 32'hFF);
    endtask

    task automatic step(string tag, bit done, bit we, int loc, int off, logic [7:0] d);
        @(negedge clk);
        abort_done = done; wr_en = we; addr = AW'((loc << WB) | off); wr_data = d;
        model(done, we, loc, off, d);
        @(negedge clk);
        abort_done = 0; wr_en = 0;
        compare(tag);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r = 32'h1234_5679;
        m_vld = 0; m_idx = 0; m_req = '0; m_take = '0; m_gone = '0; m_chg = '0; m_ab = 0; m_nxt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare("R1");
        // R2: ignored writes
        step("R2", 0, 1, 4, 0, 8'h02);
        step("R2", 0, 1, 0, 8, 8'h02);
        step("R2", 0, 1, 6, 0, 8'h02);
        // R3 / R11: grab with no owner
        step("R3", 0, 1, 1, 0, 8'h02);
        chk("R11", "pulse on loc1", loc_changed, 32'h02);
        // R4 / R7: waiting
        step("R4", 0, 1, 0, 0, 8'h02);
        step("R4", 0, 1, 2, 0, 8'h02);
        step("R4", 0, 1, 1, 0, 8'h02);
        addr = AW'(1 << WB); #1;
        chk("R7", "owner sees waiter", rd_data, 32'hA4);
        // R6: non-owner release clears own wants
        step("R6", 0, 1, 0, 0, 8'h20);
        chk("R6", "loc0 wants cleared", loc_req, 32'h04);
        // R5: release to highest waiter, then to nobody
        step("R5", 0, 1, 0, 0, 8'h02);
        step("R5", 0, 1, 1, 0, 8'h20);
        chk("R5", "new owner", active_loc, 32'h2);
        step("R5", 0, 1, 2, 0, 8'h20);
        step("R5", 0, 1, 0, 0, 8'h20);
        step("R5", 0, 1, 0, 0, 8'h20);
        chk("R11", "no pulse to nobody", loc_changed, 0);
        // R8 / R12 / R9: take-over
        step("R8", 0, 1, 0, 0, 8'h02);
        step("R8", 0, 1, 2, 0, 8'h08);
        chk("R8", "abort raised", abort_req, 1);
        step("R12", 0, 1, 1, 0, 8'h08);
        step("R12", 0, 1, 3, 0, 8'h08);
        step("R12", 0, 1, 2, 0, 8'h08);
        step("R8", 0, 0, 0, 0, 8'h00);
        step("R9", 1, 0, 0, 0, 8'h00);
        chk("R9", "taker owns", active_loc, 32'h3);
        chk("R9", "old owner forced out", loc_seized, 32'h01);
        // R10
        step("R10", 0, 1, 0, 0, 8'h00);
        step("R10", 0, 1, 0, 0, 8'h10);
        chk("R10", "flag cleared", loc_seized, 0);
        // pseudo-random sweep
        for (int n = 0; n < 3000; n++) begin
            int loc, off;
            logic [7:0] d;
            bit we, dn;
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            loc = (r[3:0] < 12) ? int'(r[7:6]) : int'(r[26:24]);
            off = (r[20:17] == 0) ? 4 : 0;
            d = {2'b00, r[9], r[10] & r[21], r[11] & r[12], 1'b0, r[13], r[22] & r[23]};
            we = r[4] | r[5];
            dn = r[15] & r[16];
            step("R12", dn, we, loc, off, d);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule